// File: doc/BRIEF.md
# Fault status capture unit

This unit records faults for a processor. Fault events from the memory-protection logic, the bus interface and the instruction decoder arrive as one-cycle pulses. Each pulse sets a sticky flag in a 32-bit configurable fault status word. The word has three fields: a memory-protection byte, a bus-fault byte and a usage-fault halfword. A separate hard-fault status word records vector-fetch faults, debug events and escalations.

Two address registers hold the faulting address. One serves memory-protection faults and the other serves precise bus faults. Each has a valid flag that lives in the status word. A register stops capturing while its valid flag is set, and clearing the flag lets it capture again.

For every accepted fault the unit raises a one-cycle request to the exception logic. The request goes to the fault's own class when that class's handler is enabled. Otherwise the unit records an escalation and raises the hard-fault request. Software reads the four words through a small register port, and a write-one-to-clear write removes status flags.

Top module: `fault_status_unit`

## Requirements
- R1: After reset, all four readable words (status, hard status, bus address, protection address) read zero and all four requests are low.
- R2: The status word is selected by reg_sel 0. An event sets its flag at the next clock edge, and the flag stays set until it is cleared. The bit positions are: bit 0 instruction access violation, bit 1 data access violation, bit 7 protection address valid, bit 8 instruction bus error, bit 9 precise data bus error, bit 10 imprecise data bus error, bit 15 bus address valid, bit 16 undefined instruction, bit 17 invalid state, bit 24 unaligned access, bit 25 divide by zero.
- R3: A write to the status word clears each bit written as 1 and leaves each bit written as 0. Writing back the value just read clears every flag that was set.
- R4: When a fault event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A data access violation captures mp_fault_addr and sets bit 7, provided bit 7 is clear. A precise data bus error captures bus_fault_addr and sets bit 15, provided bit 15 is clear. Addresses read at reg_sel 3 (protection) and reg_sel 2 (bus).
- R6: An imprecise data bus error never changes the bus address register and never sets bit 15.
- R7: While an address-valid flag is set, further capturing events leave that address register unchanged.
- R8: Clearing an address-valid flag re-arms capture. A capturing event in the same cycle as the clearing write stores the new address and keeps the flag set.
- R9: Unaligned access and divide by zero are recorded and requested only while trap_unalign_en and trap_div_en, respectively, are high. Otherwise they change no status bit and raise no request.
- R10: An accepted fault whose class handler enable is high pulses that class's request (req_mp, req_bus or req_use) for one cycle, in the cycle after the event.
- R11: An accepted fault whose class handler enable is low raises req_hard instead of the class request and sets hard-status bit 30.
- R12: The hard status word is at reg_sel 1 and is write-one-to-clear. A vector-fetch fault sets bit 1 and raises req_hard. A debug event sets bit 31 and raises no request.
- R13: Writes to the address registers (reg_sel 2 and 3) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_unalign_en | input | 1 | Report unaligned accesses as usage faults |
| trap_div_en | input | 1 | Report divide by zero as a usage fault |
| mp_handler_en | input | 1 | Memory-protection handler enabled |
| bus_handler_en | input | 1 | Bus-fault handler enabled |
| use_handler_en | input | 1 | Usage-fault handler enabled |
| f_iviol | input | 1 | Instruction access violation pulse |
| f_dviol | input | 1 | Data access violation pulse |
| mp_fault_addr | input | ADDR_W | Address for a data access violation |
| f_ibus | input | 1 | Instruction bus error pulse |
| f_dbus_precise | input | 1 | Precise data bus error pulse |
| f_dbus_imprecise | input | 1 | Imprecise data bus error pulse |
| bus_fault_addr | input | ADDR_W | Address for a precise data bus error |
| f_undef | input | 1 | Undefined instruction pulse |
| f_badstate | input | 1 | Invalid execution state pulse |
| f_unalign | input | 1 | Unaligned access pulse |
| f_divzero | input | 1 | Divide by zero pulse |
| f_vector | input | 1 | Fault on vector table fetch pulse |
| f_debug | input | 1 | Debug event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 hard status, 2 bus address, 3 protection address |
| reg_wdata | input | 32 | Write data (ones clear) |
| reg_rdata | output | 32 | Read data for reg_sel |
| req_mp | output | 1 | Memory-protection fault request |
| req_bus | output | 1 | Bus fault request |
| req_use | output | 1 | Usage fault request |
| req_hard | output | 1 | Hard fault request |

## Verification
A clearing write to the status word can land in the same cycle as a fault event that sets the same flag. The same clash can involve an address-valid flag and a new capturing bus error. The bench drives the write strobe and the event pulse in one cycle to provoke each case. It then reads the status word and the address register. It expects the flag to remain set and, for the address case, the new address to be stored rather than the old one kept.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
    localparam int STAT_W        = 32;
    // status word bit positions (software decodes these)
    localparam int MP_IACC       = 0;
    localparam int MP_DACC       = 1;
    localparam int MP_VALID      = 7;
    localparam int BUS_IBUS      = 8;
    localparam int BUS_PRECISE   = 9;
    localparam int BUS_IMPRECISE = 10;
    localparam int BUS_VALID     = 15;
    localparam int USE_UNDEF     = 16;
    localparam int USE_STATE     = 17;
    localparam int USE_UNALIGN   = 24;
    localparam int USE_DIVZERO   = 25;
    // hard status bit positions
    localparam int HF_VECT       = 1;
    localparam int HF_FORCED     = 30;
    localparam int HF_DEBUG      = 31;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_HARD    = 2'd1,
        SEL_BUSADDR = 2'd2,
        SEL_MPADDR  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/fsu_sticky.sv
module fsu_sticky #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set dominates a simultaneous clear
        st_d.bits = (st_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;

    // R2: with no clearing write no flag falls
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((q_o & $past(q_o)) == $past(q_o)));
    // R4: every requested set is present afterwards, even against a clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
    // R3: a cleared bit with no set falls
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((q_o & $past(clr_i)) == '0));
endmodule

// File: rtl/fsu_addr_cap.sv
module fsu_addr_cap #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic          clr_i,
    input  logic [AW-1:0] addr_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
    } cap_t;

    cap_t cap_d, cap_q;
    logic armed;

    always_comb begin
        cap_d = cap_q;
        armed = !cap_q.valid || clr_i;
        if (capture_i && armed) begin
            cap_d.valid = 1'b1;
            cap_d.addr  = addr_i;
        end else if (clr_i) begin
            cap_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign valid_o = cap_q.valid;
    assign addr_o  = cap_q.addr;

    // R5: capture into an empty register
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && !valid_o) |=> (valid_o && (addr_o == $past(addr_i))));
    // R7: held address is not overwritten
    a_r7_keep_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !clr_i) |=> (valid_o && $stable(addr_o)));
    // R8: clear without capture drops the flag
    a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !capture_i) |=> !valid_o);
endmodule

// File: rtl/fsu_escalate.sv
module fsu_escalate (
    input  logic clk,
    input  logic rst_n,
    input  logic mp_hit_i,
    input  logic bus_hit_i,
    input  logic usg_hit_i,
    input  logic vect_hit_i,
    input  logic mp_en_i,
    input  logic bus_en_i,
    input  logic usg_en_i,
    output logic forced_o,
    output logic req_mp_o,
    output logic req_bus_o,
    output logic req_usg_o,
    output logic req_hard_o
);
    typedef struct packed {
        logic mp;
        logic bus;
        logic usg;
        logic hard;
    } req_t;

    req_t req_d, req_q;
    logic esc;

    always_comb begin
        esc       = (mp_hit_i  && !mp_en_i)
                 || (bus_hit_i && !bus_en_i)
                 || (usg_hit_i && !usg_en_i);
        req_d.mp   = mp_hit_i  && mp_en_i;
        req_d.bus  = bus_hit_i && bus_en_i;
        req_d.usg  = usg_hit_i && usg_en_i;
        req_d.hard = esc || vect_hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign forced_o   = esc;
    assign req_mp_o   = req_q.mp;
    assign req_bus_o  = req_q.bus;
    assign req_usg_o  = req_q.usg;
    assign req_hard_o = req_q.hard;

    // R11: disabled class escalates, its own request stays low
    a_r11_mp_escalate: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_hit_i && !mp_en_i) |=> (req_hard_o && !req_mp_o));
    a_r11_bus_escalate: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hit_i && !bus_en_i) |=> (req_hard_o && !req_bus_o));
    a_r11_use_escalate: assert property (@(posedge clk) disable iff (!rst_n)
        (usg_hit_i && !usg_en_i) |=> (req_hard_o && !req_usg_o));
    // R10: enabled class fault requests its class next cycle
    a_r10_class_req: assert property (@(posedge clk) disable iff (!rst_n)
        (usg_hit_i && usg_en_i) |=> req_usg_o);
endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_unalign_en,
    input  logic              trap_div_en,
    input  logic              mp_handler_en,
    input  logic              bus_handler_en,
    input  logic              use_handler_en,
    input  logic              f_iviol,
    input  logic              f_dviol,
    input  logic [ADDR_W-1:0] mp_fault_addr,
    input  logic              f_ibus,
    input  logic              f_dbus_precise,
    input  logic              f_dbus_imprecise,
    input  logic [ADDR_W-1:0] bus_fault_addr,
    input  logic              f_undef,
    input  logic              f_badstate,
    input  logic              f_unalign,
    input  logic              f_divzero,
    input  logic              f_vector,
    input  logic              f_debug,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              req_mp,
    output logic              req_bus,
    output logic              req_use,
    output logic              req_hard
);
    import fsu_pkg::*;

    logic              unalign_ok, div_ok;
    logic              mp_hit, bus_hit, usg_hit;
    logic              wr_stat, wr_hard;
    logic [STAT_W-1:0] cfsr_set, cfsr_clr, cfsr_q, cfsr_rd;
    logic [STAT_W-1:0] hfsr_set, hfsr_clr, hfsr_q;
    logic              forced;
    logic              mp_valid, bus_valid;
    logic [ADDR_W-1:0] mp_addr_q, bus_addr_q;

    always_comb begin
        unalign_ok = f_unalign && trap_unalign_en;
        div_ok     = f_divzero && trap_div_en;
        mp_hit     = f_iviol || f_dviol;
        bus_hit    = f_ibus || f_dbus_precise || f_dbus_imprecise;
        usg_hit    = f_undef || f_badstate || unalign_ok || div_ok;
        wr_stat    = reg_wr && (reg_sel == SEL_STATUS);
        wr_hard    = reg_wr && (reg_sel == SEL_HARD);

        cfsr_set                = '0;
        cfsr_set[MP_IACC]       = f_iviol;
        cfsr_set[MP_DACC]       = f_dviol;
        cfsr_set[BUS_IBUS]      = f_ibus;
        cfsr_set[BUS_PRECISE]   = f_dbus_precise;
        cfsr_set[BUS_IMPRECISE] = f_dbus_imprecise;
        cfsr_set[USE_UNDEF]     = f_undef;
        cfsr_set[USE_STATE]     = f_badstate;
        cfsr_set[USE_UNALIGN]   = unalign_ok;
        cfsr_set[USE_DIVZERO]   = div_ok;
        cfsr_clr                = wr_stat ? reg_wdata : '0;

        hfsr_set            = '0;
        hfsr_set[HF_VECT]   = f_vector;
        hfsr_set[HF_FORCED] = forced;
        hfsr_set[HF_DEBUG]  = f_debug;
        hfsr_clr            = wr_hard ? reg_wdata : '0;
    end

    fsu_sticky #(.W(STAT_W)) u_cfsr (
        .clk(clk), .rst_n(rst_n), .set_i(cfsr_set), .clr_i(cfsr_clr), .q_o(cfsr_q)
    );

    fsu_sticky #(.W(STAT_W)) u_hfsr (
        .clk(clk), .rst_n(rst_n), .set_i(hfsr_set), .clr_i(hfsr_clr), .q_o(hfsr_q)
    );

    fsu_addr_cap #(.AW(ADDR_W)) u_mp_cap (
        .clk(clk), .rst_n(rst_n),
        .capture_i(f_dviol),
        .clr_i(wr_stat && reg_wdata[MP_VALID]),
        .addr_i(mp_fault_addr),
        .valid_o(mp_valid), .addr_o(mp_addr_q)
    );

    fsu_addr_cap #(.AW(ADDR_W)) u_bus_cap (
        .clk(clk), .rst_n(rst_n),
        .capture_i(f_dbus_precise),
        .clr_i(wr_stat && reg_wdata[BUS_VALID]),
        .addr_i(bus_fault_addr),
        .valid_o(bus_valid), .addr_o(bus_addr_q)
    );

    fsu_escalate u_esc (
        .clk(clk), .rst_n(rst_n),
        .mp_hit_i(mp_hit), .bus_hit_i(bus_hit), .usg_hit_i(usg_hit),
        .vect_hit_i(f_vector),
        .mp_en_i(mp_handler_en), .bus_en_i(bus_handler_en), .usg_en_i(use_handler_en),
        .forced_o(forced),
        .req_mp_o(req_mp), .req_bus_o(req_bus), .req_usg_o(req_use), .req_hard_o(req_hard)
    );

    always_comb begin
        cfsr_rd            = cfsr_q;
        cfsr_rd[MP_VALID]  = mp_valid;
        cfsr_rd[BUS_VALID] = bus_valid;
        unique case (reg_sel)
            SEL_STATUS:  reg_rdata = cfsr_rd;
            SEL_HARD:    reg_rdata = hfsr_q;
            SEL_BUSADDR: reg_rdata = 32'(bus_addr_q);
            default:     reg_rdata = 32'(mp_addr_q);
        endcase
    end

    // R6: an imprecise error alone leaves the bus address and its flag alone
    a_r6_imprecise_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (f_dbus_imprecise && !f_dbus_precise && !wr_stat)
        |=> ($stable(bus_addr_q) && $stable(bus_valid)));
    // R9: a disabled trap never records divide by zero
    a_r9_div_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_div_en && !cfsr_rd[USE_DIVZERO]) |=> !cfsr_rd[USE_DIVZERO]);
    // R9: a disabled trap never records an unaligned access
    a_r9_unalign_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_unalign_en && !cfsr_rd[USE_UNALIGN]) |=> !cfsr_rd[USE_UNALIGN]);
    // R12: every hard request is explained by a hard status bit
    a_r12_hard_cause: assert property (@(posedge clk) disable iff (!rst_n)
        req_hard |-> (hfsr_q[HF_FORCED] || hfsr_q[HF_VECT]));
    // R12: a debug event alone raises no request
    a_r12_debug_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (f_debug && !f_vector && !mp_hit && !bus_hit && !usg_hit)
        |=> !(req_hard || req_mp || req_bus || req_use));
endmodule

// File: tb/fault_status_unit_tb.sv
module fault_status_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_unalign_en, trap_div_en;
    logic        mp_handler_en, bus_handler_en, use_handler_en;
    logic        f_iviol, f_dviol, f_ibus, f_dbus_precise, f_dbus_imprecise;
    logic [31:0] mp_fault_addr, bus_fault_addr;
    logic        f_undef, f_badstate, f_unalign, f_divzero, f_vector, f_debug;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata, reg_rdata;
    logic        req_mp, req_bus, req_use, req_hard;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_status_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .trap_unalign_en(trap_unalign_en), .trap_div_en(trap_div_en),
        .mp_handler_en(mp_handler_en), .bus_handler_en(bus_handler_en),
        .use_handler_en(use_handler_en),
        .f_iviol(f_iviol), .f_dviol(f_dviol), .mp_fault_addr(mp_fault_addr),
        .f_ibus(f_ibus), .f_dbus_precise(f_dbus_precise),
        .f_dbus_imprecise(f_dbus_imprecise), .bus_fault_addr(bus_fault_addr),
        .f_undef(f_undef), .f_badstate(f_badstate), .f_unalign(f_unalign),
        .f_divzero(f_divzero), .f_vector(f_vector), .f_debug(f_debug),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .req_mp(req_mp), .req_bus(req_bus), .req_use(req_use), .req_hard(req_hard)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic quiet();
        f_iviol = 0; f_dviol = 0; f_ibus = 0; f_dbus_precise = 0; f_dbus_imprecise = 0;
        f_undef = 0; f_badstate = 0; f_unalign = 0; f_divzero = 0;
        f_vector = 0; f_debug = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    // one clock: inputs driven now take effect at the coming edge
    task automatic tick();
        @(negedge clk);
        quiet();
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic drive_wr(input logic [1:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    endtask

    function automatic logic [31:0] reqs();
        return {28'd0, req_hard, req_use, req_bus, req_mp};
    endfunction

    task automatic clear_all();
        logic [31:0] v;
        rd(2'd0, v); drive_wr(2'd0, v); tick();
        rd(2'd1, v); drive_wr(2'd1, v); tick();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk("R1 status", v, 32'h0);
        rd(2'd1, v); chk("R1 hard", v, 32'h0);
        rd(2'd2, v); chk("R1 bus addr", v, 32'h0);
        rd(2'd3, v); chk("R1 mp addr", v, 32'h0);
        chk("R1 requests", reqs(), 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        f_iviol = 1; tick();
        chk("R10 req_mp pulse", reqs(), 32'h1);
        tick();
        chk("R10 req_mp one cycle", reqs(), 32'h0);
        f_ibus = 1; tick();
        chk("R10 req_bus", reqs(), 32'h2);
        f_undef = 1; f_badstate = 1; tick();
        chk("R10 req_use", reqs(), 32'h4);
        tick(); tick();
        rd(2'd0, v); chk("R2 layout sticky", v, 32'h0003_0101);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        drive_wr(2'd0, 32'h0000_0001); tick();
        rd(2'd0, v); chk("R3 single clear", v, 32'h0003_0100);
        rd(2'd0, v); drive_wr(2'd0, v); tick();
        rd(2'd0, v); chk("R3 write back clears", v, 32'h0);
    endtask

    task automatic t_capture();
        logic [31:0] v;
        f_dviol = 1; mp_fault_addr = 32'h2000_0010; tick();
        rd(2'd0, v); chk("R5 mp valid", v, 32'h0000_0082);
        rd(2'd3, v); chk("R5 mp addr", v, 32'h2000_0010);
        f_dviol = 1; mp_fault_addr = 32'h2000_0020; tick();
        rd(2'd3, v); chk("R7 mp addr kept", v, 32'h2000_0010);
        f_dbus_imprecise = 1; bus_fault_addr = 32'h4000_0004; tick();
        rd(2'd0, v); chk("R6 imprecise flag only", v, 32'h0000_0482);
        rd(2'd2, v); chk("R6 bus addr untouched", v, 32'h0);
        f_dbus_precise = 1; bus_fault_addr = 32'h4000_0008; tick();
        rd(2'd0, v); chk("R5 bus valid", v, 32'h0000_8682);
        rd(2'd2, v); chk("R5 bus addr", v, 32'h4000_0008);
        drive_wr(2'd0, 32'h0000_0080); tick();
        rd(2'd0, v); chk("R8 mp valid cleared", v, 32'h0000_8602);
        f_dviol = 1; mp_fault_addr = 32'h2000_0030; tick();
        rd(2'd3, v); chk("R8 re-armed capture", v, 32'h2000_0030);
        drive_wr(2'd0, 32'h0000_8000);
        f_dbus_precise = 1; bus_fault_addr = 32'h4000_000C; tick();
        rd(2'd0, v); chk("R8 clear+capture flag", v, 32'h0000_8682);
        rd(2'd2, v); chk("R8 clear+capture addr", v, 32'h4000_000C);
        drive_wr(2'd3, 32'hFFFF_FFFF); tick();
        rd(2'd3, v); chk("R13 mp addr read-only", v, 32'h2000_0030);
        drive_wr(2'd2, 32'hFFFF_FFFF); tick();
        rd(2'd2, v); chk("R13 bus addr read-only", v, 32'h4000_000C);
        clear_all();
        rd(2'd0, v); chk("R3 all cleared", v, 32'h0);
    endtask

    task automatic t_trap();
        logic [31:0] v;
        trap_div_en = 0; trap_unalign_en = 0;
        f_divzero = 1; f_unalign = 1; tick();
        chk("R9 no request when off", reqs(), 32'h0);
        rd(2'd0, v); chk("R9 no flag when off", v, 32'h0);
        trap_div_en = 1; trap_unalign_en = 1;
        f_divzero = 1; f_unalign = 1; tick();
        chk("R9 request when on", reqs(), 32'h4);
        rd(2'd0, v); chk("R9 flags when on", v, 32'h0300_0000);
        clear_all();
    endtask

    task automatic t_setwins();
        logic [31:0] v;
        f_undef = 1; tick();
        drive_wr(2'd0, 32'h0001_0000); f_undef = 1; tick();
        rd(2'd0, v); chk("R4 set beats clear", v, 32'h0001_0000);
        clear_all();
    endtask

    task automatic t_escalate();
        logic [31:0] v;
        use_handler_en = 0;
        f_undef = 1; tick();
        chk("R11 hard instead of use", reqs(), 32'h8);
        rd(2'd1, v); chk("R11 forced bit", v, 32'h4000_0000);
        rd(2'd0, v); chk("R11 fault still recorded", v, 32'h0001_0000);
        use_handler_en = 1;
        bus_handler_en = 0;
        f_ibus = 1; tick();
        chk("R11 bus escalates", reqs(), 32'h8);
        bus_handler_en = 1;
        clear_all();
    endtask

    task automatic t_hard();
        logic [31:0] v;
        f_vector = 1; tick();
        chk("R12 vector requests hard", reqs(), 32'h8);
        f_debug = 1; tick();
        chk("R12 debug no request", reqs(), 32'h0);
        rd(2'd1, v); chk("R12 hard bits", v, 32'h8000_0002);
        drive_wr(2'd1, 32'h0000_0002); tick();
        rd(2'd1, v); chk("R12 hard w1c", v, 32'h8000_0000);
        clear_all();
        rd(2'd1, v); chk("R12 hard cleared", v, 32'h0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        quiet();
        reg_sel = 2'd0;
        mp_fault_addr = '0; bus_fault_addr = '0;
        trap_unalign_en = 1; trap_div_en = 1;
        mp_handler_en = 1; bus_handler_en = 1; use_handler_en = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_w1c();
        t_capture();
        t_trap();
        t_setwins();
        t_escalate();
        t_hard();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule